// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns pin activity into interrupt requests for a small 8-bit processor. It watches two dedicated external interrupt lines. Each line has its own sense mode: low level, any change, falling edge or rising edge. It also watches sixteen pin-change inputs. Each of these inputs is qualified by a bit in a mask, and the inputs are split into two enable groups that feed one shared pin-change flag.

Software sees two 8-bit registers on a simple register bus: an enable register and a flag register. A request goes to the processor when a flag, its enable bit and the global interrupt enable are all set. A flag is cleared when software writes a one to it, or when the processor acknowledges the matching vector.

Each external line runs a two-state tracker with the states `ST_LOW` and `ST_HIGH`. The tracker steps through the transitions `T_RISE` (`ST_LOW` to `ST_HIGH`) and `T_FALL` (`ST_HIGH` to `ST_LOW`), and it stays in place while the synchronized pin is unchanged. The selected sense mode decides which transition counts as a trigger.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, both the enable register (address 0) and the flag register (address 1) read 8'h00.
- R2: In the enable register, bit 7 enables external line 1 and bit 6 enables external line 0. Bit 5 enables pin-change group 1, which covers inputs 7:0 and 15:12. Bit 4 enables pin-change group 0, which covers inputs 11:8. Bits 3:0 always read zero.
- R3: In the flag register, bit 7 is the line-1 flag, bit 6 is the line-0 flag and bit 5 is the pin-change flag. Bits 4:0 read zero, and writes to them have no effect.
- R4: The sense mode encoding is 2'b00 low level, 2'b01 any change, 2'b10 falling edge and 2'b11 rising edge (line 0 uses sense_mode[1:0], line 1 uses sense_mode[3:2]). The flag sets only on the selected activity, and it is readable after the third rising clock edge that follows the pin change.
- R5: A change on a pin-change input sets the pin-change flag only when its mask bit is set and its group is enabled.
- R6: Bit 2 of req belongs to line 1, bit 1 to line 0 and bit 0 to pin change. A request is high only when its flag, its enable and global_ie are all one. The pin-change request uses either group enable.
- R7: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R8: An acknowledge on ack (bit mapping as for req) clears the matching flag.
- R9: While a line is in low-level mode, its flag reads zero. Its request then follows the synchronized pin being low, gated by the line's enable and global_ie.
- R10: If a trigger and a clear land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 2 | External interrupt lines |
| pc_pin | input | 16 | Pin-change inputs |
| pc_mask | input | 16 | Per-input pin-change qualifier |
| sense_mode | input | 4 | Sense mode per external line |
| global_ie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the enable register, 1 selects the flag register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| ack | input | 3 | Vector acknowledge per source |
| req | output | 3 | Interrupt requests per source |

## Verification
The bench builds the block with its default parameters: sixteen pin-change inputs, with group 0 placed on inputs 11:8. With these values it can toggle a pin inside each group's range, including both the lower and the upper part of group 1, while the other group is enabled alone. This shows the uneven split between the groups. A vector table covers every edge sense mode with both pin directions. Directed cases then line a write-one clear up with a trigger in the same edge, and move a line into low-level mode while its flag is set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_t;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } line_state_t;

    localparam int NUM_EXT    = 2;
    localparam logic ADDR_EN   = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;
    localparam int BIT_PCF    = 5;
    localparam int BIT_EXT0   = 6;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irqc_line_fsm.sv
module irqc_line_fsm
    import irqc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_t mode,
    output logic   hit,
    output logic   level_req
);
    line_state_t state, state_nx;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        rise     = 1'b0;
        fall     = 1'b0;
        unique case (state)
            ST_LOW: if (pin_s) begin
                state_nx = ST_HIGH;   // T_RISE
                rise     = 1'b1;
            end
            ST_HIGH: if (!pin_s) begin
                state_nx = ST_LOW;    // T_FALL
                fall     = 1'b1;
            end
        endcase
    end

    always_comb begin
        hit       = 1'b0;
        level_req = 1'b0;
        unique case (mode)
            SENSE_LOW:  level_req = !pin_s;
            SENSE_ANY:  hit = rise | fall;
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
        endcase
    end
endmodule

// File: rtl/irqc_pc_detect.sv
module irqc_pc_detect #(
    parameter int             NPC      = 16,
    parameter logic [NPC-1:0] G0_PINS  = 16'h0F00
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPC-1:0] pins_s,
    input  logic [NPC-1:0] mask,
    input  logic [1:0]     grp_en,
    output logic           change
);
    logic [NPC-1:0] prev;
    logic [NPC-1:0] pin_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= pins_s;
    end

    for (genvar i = 0; i < NPC; i++) begin : g_pin
        if (G0_PINS[i]) begin : g_grp0
            assign pin_en[i] = grp_en[0];
        end else begin : g_grp1
            assign pin_en[i] = grp_en[1];
        end
    end

    assign change = |((pins_s ^ prev) & mask & pin_en);
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import irqc_pkg::*;
#(
    parameter int             NPC     = 16,
    parameter logic [NPC-1:0] G0_PINS = 16'h0F00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   ext_pin,
    input  logic [NPC-1:0]       pc_pin,
    input  logic [NPC-1:0]       pc_mask,
    input  logic [2*NUM_EXT-1:0] sense_mode,
    input  logic                 global_ie,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NUM_EXT:0]     ack,
    output logic [NUM_EXT:0]     req
);
    logic [NUM_EXT-1:0] ext_s, hit, lvl_req, is_level, flag_ext, ext_nx, clr_ext;
    logic [NPC-1:0]     pc_s;
    logic [3:0]         en_q;
    logic               flag_pc, pc_nx, pc_change, clr_pc, wr_flag;

    irqc_sync #(.WIDTH(NUM_EXT)) u_sync_ext (.clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s));
    irqc_sync #(.WIDTH(NPC))     u_sync_pc  (.clk(clk), .rst_n(rst_n), .d(pc_pin),  .q(pc_s));

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_line
        sense_t mode;
        assign mode        = sense_t'(sense_mode[2*g +: 2]);
        assign is_level[g] = (mode == SENSE_LOW);
        irqc_line_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .pin_s(ext_s[g]), .mode(mode),
            .hit(hit[g]), .level_req(lvl_req[g])
        );
    end

    irqc_pc_detect #(.NPC(NPC), .G0_PINS(G0_PINS)) u_pc (
        .clk(clk), .rst_n(rst_n), .pins_s(pc_s), .mask(pc_mask),
        .grp_en(en_q[1:0]), .change(pc_change)
    );

    assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);

    always_comb begin
        for (int g = 0; g < NUM_EXT; g++) begin
            clr_ext[g] = (wr_flag && reg_wdata[BIT_EXT0+g]) || ack[1+g];
            if (is_level[g])   ext_nx[g] = 1'b0;
            else if (hit[g])   ext_nx[g] = 1'b1;
            else if (clr_ext[g]) ext_nx[g] = 1'b0;
            else               ext_nx[g] = flag_ext[g];
        end
        clr_pc = (wr_flag && reg_wdata[BIT_PCF]) || ack[0];
        pc_nx  = pc_change ? 1'b1 : (clr_pc ? 1'b0 : flag_pc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            flag_ext <= '0;
            flag_pc  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == ADDR_EN)) en_q <= reg_wdata[7:4];
            flag_ext <= ext_nx;
            flag_pc  <= pc_nx;
        end
    end

    always_comb begin
        req[0] = global_ie && (en_q[1] || en_q[0]) && flag_pc;
        for (int g = 0; g < NUM_EXT; g++)
            req[1+g] = global_ie && en_q[2+g] && (is_level[g] ? lvl_req[g] : flag_ext[g]);
    end

    always_comb begin
        if (reg_addr == ADDR_EN)
            reg_rdata = {en_q, 4'b0000};
        else
            reg_rdata = {flag_ext & ~is_level, flag_pc, 5'b00000};
    end
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       global_ie,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [3:0] sense_mode,
    input logic [2:0] ack,
    input logic [2:0] req,
    input logic [1:0] ext_hit,
    input logic [1:0] flag_ext,
    input logic       flag_pc,
    input logic       pc_change
);
    a_r2_en_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> reg_rdata[3:0] == 4'h0);

    a_r3_flag_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr |-> reg_rdata[4:0] == 5'h00);

    a_r6_no_req_without_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !global_ie |-> req == 3'b000);

    a_r7_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && reg_wdata[5] && !pc_change) |=> !flag_pc);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !pc_change) |=> !flag_pc);

    a_r9_level_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_mode[1:0] == 2'b00 && reg_addr) |-> !reg_rdata[6]);

    a_r10_ext_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit[0] |=> flag_ext[0]);

    a_r10_pc_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pc_change |=> flag_pc);
endmodule

bind extirq_ctrl extirq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .global_ie(global_ie), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sense_mode(sense_mode), .ack(ack), .req(req), .ext_hit(hit),
    .flag_ext(flag_ext), .flag_pc(flag_pc), .pc_change(pc_change)
);

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin = '0;
    logic [15:0] pc_pin = '0;
    logic [15:0] pc_mask = '0;
    logic [3:0]  sense_mode = 4'b1111;
    logic        global_ie = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  ack = '0;
    logic [2:0]  req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // {mode[1:0], pin before, pin after, expected flag}
    localparam logic [4:0] VEC [0:5] = '{
        5'b11_0_1_1, 5'b11_1_0_0,
        5'b10_1_0_1, 5'b10_0_1_0,
        5'b01_0_1_1, 5'b01_1_0_1
    };

    extirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pc_pin(pc_pin),
        .pc_mask(pc_mask), .sense_mode(sense_mode), .global_ie(global_ie),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack(ack), .req(req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] rd(input logic a);
        reg_addr = a;
        return reg_rdata;
    endfunction

    task automatic read_chk(input string tag, input logic a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic req_chk(input string tag, input logic [2:0] exp);
        #1;
        check(tag, {5'b0, req}, {5'b0, exp});
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        read_chk("R1 enable reset", 1'b0, 8'h00);
        read_chk("R1 flag reset", 1'b1, 8'h00);

        // R4 sense modes on line 0, R7 clear by writing one
        for (int i = 0; i < 6; i++) begin
            sense_mode[1:0] = VEC[i][4:3];
            ext_pin[0] = VEC[i][2];
            tick(4);
            wr(1'b1, 8'h40);
            read_chk("R7 write one clears line-0 flag", 1'b1, 8'h00);
            ext_pin[0] = VEC[i][1];
            tick(4);
            read_chk("R4 sense mode vector", 1'b1, {1'b0, VEC[i][0], 6'b0});
        end
        // line 0 is now low with its flag set in any-change mode
        wr(1'b1, 8'h00);
        read_chk("R7 write zero keeps flag", 1'b1, 8'h40);
        wr(1'b1, 8'h1F);
        read_chk("R3 reserved writes ignored", 1'b1, 8'h40);

        // R10 trigger and write-one clear in the same edge
        sense_mode[1:0] = 2'b11;
        wr(1'b1, 8'h40);
        ext_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h40;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        read_chk("R10 trigger beats clear", 1'b1, 8'h40);
        wr(1'b1, 8'h40);

        // R2 enable register layout
        wr(1'b0, 8'hFF);
        read_chk("R2 enable low nibble zero", 1'b0, 8'hF0);
        wr(1'b0, 8'h00);

        // R9 low-level mode on line 1
        global_ie = 1'b1;
        wr(1'b0, 8'h80);
        ext_pin[1] = 1'b1;
        tick(4);
        read_chk("R9 flag before level mode", 1'b1, 8'h80);
        sense_mode[3:2] = 2'b00;
        read_chk("R9 flag reads zero in level mode", 1'b1, 8'h00);
        req_chk("R9 no request while high", 3'b000);
        ext_pin[1] = 1'b0;
        tick(4);
        req_chk("R9 request follows low level", 3'b100);
        read_chk("R9 flag stays zero while low", 1'b1, 8'h00);
        ext_pin[1] = 1'b1;
        tick(4);
        req_chk("R9 request drops when high", 3'b000);
        sense_mode[3:2] = 2'b11;
        wr(1'b0, 8'h00);

        // R5 / R6 / R8 pin change groups
        pc_mask = 16'h0200;
        wr(1'b0, 8'h20);
        pc_pin[9] = 1'b1;
        tick(4);
        read_chk("R5 group0 pin with only group1 enabled", 1'b1, 8'h00);
        wr(1'b0, 8'h10);
        pc_pin[9] = 1'b0;
        tick(4);
        read_chk("R5 group0 pin sets flag", 1'b1, 8'h20);
        req_chk("R6 pin-change request", 3'b001);
        global_ie = 1'b0;
        req_chk("R6 request gated by global enable", 3'b000);
        global_ie = 1'b1;
        wr(1'b0, 8'h00);
        req_chk("R6 request gated by group enable", 3'b000);
        @(negedge clk);
        ack = 3'b001;
        @(posedge clk);
        @(negedge clk);
        ack = 3'b000;
        read_chk("R8 acknowledge clears flag", 1'b1, 8'h00);

        pc_mask = 16'h0008;
        wr(1'b0, 8'h20);
        pc_pin[2] = 1'b1;
        tick(4);
        read_chk("R5 unmasked pin ignored", 1'b1, 8'h00);
        pc_pin[3] = 1'b1;
        tick(4);
        read_chk("R5 group1 low range sets flag", 1'b1, 8'h20);
        wr(1'b1, 8'h20);
        pc_mask = 16'h2000;
        wr(1'b0, 8'h10);
        pc_pin[13] = 1'b1;
        tick(4);
        read_chk("R5 group1 high range ignored by group0", 1'b1, 8'h00);
        wr(1'b0, 8'h20);
        pc_pin[13] = 1'b0;
        tick(4);
        read_chk("R5 group1 high range sets flag", 1'b1, 8'h20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule